// File: doc/BRIEF.md
# Synchronous Bus Read Master

This block is the master side of a synchronous memory bus. Every transaction is built from whole bus-clock cycles. A local client hands it one request: an address, a read/write flag and, for reads, an optional block flag with a word count. The master then runs a fixed cycle sequence. In the address cycle (T1) it drives the address. In the middle cycle (T2) the slave may ask for wait states. In the data cycle (T3) the read word is captured.

The memory-request and read strobes rise on the falling clock edge inside T1, once the address has had half a cycle to settle. They stay up until the final data cycle ends. Read data is taken into an internal register on the falling edge of each data cycle and is handed to the client one cycle later with a valid pulse and a word index. In a block read the master raises a block flag and puts the word count on the outgoing data lines during T1. The slave then returns one word per cycle, starting in T3, until the count is used up. When the transaction finishes, the master drops the strobes and pulses `done`. It also raises `busy` for the whole transaction, so a client holds a new request until the master is free.

Top module: `sync_bus_master`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `word_valid`, `bus_mreq`, `bus_rd`, `bus_block` and `bus_dout_en` are all 0.
- R2: With `busy` low, a request with `req_valid` high is accepted at the next rising edge. The following cycle is T1: `busy` is high and `bus_addr` shows the request address. `bus_addr` stays unchanged until the transaction ends.
- R3: `bus_mreq` rises at the falling edge inside T1 and stays high through the final data cycle. `bus_rd` equals `bus_mreq` for reads and stays 0 for writes.
- R4: `bus_wait` is sampled at the end of T2 and at the end of each wait cycle. Every high sample adds one wait cycle before T3, so a single read keeps `busy` high for 3 + W cycles, where W is the number of wait cycles.
- R5: Read data on `bus_din` is captured at the falling edge of each data cycle. It appears on `word_data` with a one-cycle `word_valid` pulse in the cycle after that data cycle, and `word_idx` gives the word's position from 0.
- R6: A block read (`req_block`=1, `req_write`=0) raises `bus_block` only in T1. During T1 it also drives `req_count`, zero-extended, onto `bus_dout` with `bus_dout_en`=1. It collects N words, one per cycle, where N is the count and a count of 0 means 1. `busy` is high for 2 + W + N cycles.
- R7: A write keeps `bus_rd` at 0 and drives `req_wdata` on `bus_dout` with `bus_dout_en`=1 from T2 through T3. `req_block` has no effect on a write: `bus_block` stays 0. No word is returned, and `busy` is high for 3 + W cycles.
- R8: `done` is a single-cycle pulse in the first idle cycle after the final data cycle. In that cycle `bus_mreq`, `bus_rd` and `bus_dout_en` are 0.
- R9: A request raised while `busy` is high is not lost. It stays pending and is accepted at the rising edge that ends the `done` cycle of the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; cycles start on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_block | input | 1 | Block read request (ignored for writes) |
| req_addr | input | AW | Transaction address |
| req_count | input | CW | Block word count, 0 means one word |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Transaction in flight; requests are held off |
| done | output | 1 | One-cycle completion pulse |
| word_valid | output | 1 | One-cycle pulse: a read word is available |
| word_data | output | DW | Captured read word |
| word_idx | output | CW | Position of the word inside the transaction |
| bus_addr | output | AW | Address lines |
| bus_mreq | output | 1 | Memory-request strobe |
| bus_rd | output | 1 | Read strobe |
| bus_block | output | 1 | Block-transfer flag, T1 only |
| bus_wait | input | 1 | Slave wait request |
| bus_din | input | DW | Data lines from the slave |
| bus_dout | output | DW | Data lines to the slave (count or write data) |
| bus_dout_en | output | 1 | Master drives `bus_dout` |

## Verification
A sequencer stuck in the wait phase, or leaving it one cycle early, changes the number of cycles `busy` stays high. It also moves the `word_valid` pulse, so the fault shows within the same transaction. A wrong word counter or a capture on the wrong edge gives a wrong `word_data`, a wrong `word_idx` or a wrong number of pulses, and these are compared against a reference copy of the memory on the very next cycle. A strobe register that fails to clear leaves `bus_mreq` high in the `done` cycle. A dropped held-off request shows up as a missing second T1 one cycle after `done`.

// File: rtl/sbm_pkg.sv
`timescale 1ns/1ps
package sbm_pkg;

  // Bus cycle currently being run by the master.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_BLK  = 3'd5
  } phase_e;

  // A cycle whose falling edge captures a data word.
  function automatic logic ph_data(input phase_e p);
    return (p == PH_T3) || (p == PH_BLK);
  endfunction

  // A cycle at whose end the slave's wait line is sampled.
  function automatic logic ph_wait_sample(input phase_e p);
    return (p == PH_T2) || (p == PH_TW);
  endfunction

endpackage

// File: rtl/sbm_seq.sv
`timescale 1ns/1ps
module sbm_seq
  import sbm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_block,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  input  logic [DW-1:0] req_wdata,
  input  logic          bus_wait,
  output phase_e        phase,
  output logic [AW-1:0] addr_q,
  output logic          write_q,
  output logic          block_q,
  output logic [CW-1:0] count_q,
  output logic [DW-1:0] wdata_q,
  output logic [CW-1:0] idx_q,
  output logic          accept,
  output logic          done
);
  localparam int IW = CW + 1;

  // Number of words a request asks for; a zero count still moves one word.
  function automatic logic [CW-1:0] words_of(input logic [CW-1:0] c);
    return (c == '0) ? CW'(1) : c;
  endfunction

  // True when word index i is the final one of t words.
  function automatic logic at_last(input logic [CW-1:0] i, input logic [CW-1:0] t);
    return (IW'(i) + IW'(1)) >= IW'(t);
  endfunction

  logic [CW-1:0] total_q;
  logic          last_word;
  logic          blk_req;

  assign accept    = req_valid && (phase == PH_IDLE);
  assign last_word = write_q || at_last(idx_q, total_q);
  assign blk_req   = req_block && !req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      block_q <= 1'b0;
      count_q <= '0;
      wdata_q <= '0;
      idx_q   <= '0;
      total_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            block_q <= blk_req;
            count_q <= req_count;
            wdata_q <= req_wdata;
            idx_q   <= '0;
            total_q <= blk_req ? words_of(req_count) : CW'(1);
            phase   <= PH_T1;
          end
        end
        PH_T1: phase <= PH_T2;
        PH_T2, PH_TW: phase <= bus_wait ? PH_TW : PH_T3;
        PH_T3, PH_BLK: begin
          if (last_word) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            idx_q <= idx_q + CW'(1);
            phase <= PH_BLK;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbm_drive.sv
`timescale 1ns/1ps
module sbm_drive
  import sbm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic [AW-1:0] addr_q,
  input  logic          write_q,
  input  logic          block_q,
  input  logic [CW-1:0] count_q,
  input  logic [DW-1:0] wdata_q,
  output logic [AW-1:0] bus_addr,
  output logic          bus_mreq,
  output logic          bus_rd,
  output logic          bus_block,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_en
);
  logic arm_q;
  logic active;
  logic count_drive;
  logic write_drive;

  assign active = (phase != PH_IDLE);

  // Arms the strobes half a cycle after the address goes out.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= active;
  end

  assign count_drive = (phase == PH_T1) && block_q;
  assign write_drive = write_q && (ph_wait_sample(phase) || (phase == PH_T3));

  assign bus_addr    = addr_q;
  assign bus_mreq    = arm_q && active;
  assign bus_rd      = bus_mreq && !write_q;
  assign bus_block   = count_drive;
  assign bus_dout_en = count_drive || write_drive;
  assign bus_dout    = count_drive ? DW'(count_q) :
                       write_drive ? wdata_q      : '0;

endmodule

// File: rtl/sbm_capture.sv
`timescale 1ns/1ps
module sbm_capture #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] bus_din,
  input  logic [CW-1:0] idx_in,
  output logic          word_valid,
  output logic [DW-1:0] word_data,
  output logic [CW-1:0] word_idx
);
  logic [DW-1:0] fall_q;

  // Data lines are taken on the falling edge of the data cycle.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)       fall_q <= '0;
    else if (capture) fall_q <= bus_din;
  end

  // Hand the word to the client for one full cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_data  <= '0;
      word_idx   <= '0;
    end else begin
      word_valid <= capture;
      if (capture) begin
        word_data <= fall_q;
        word_idx  <= idx_in;
      end
    end
  end

endmodule

// File: rtl/sync_bus_master.sv
`timescale 1ns/1ps
module sync_bus_master
  import sbm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_block,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic          word_valid,
  output logic [DW-1:0] word_data,
  output logic [CW-1:0] word_idx,
  output logic [AW-1:0] bus_addr,
  output logic          bus_mreq,
  output logic          bus_rd,
  output logic          bus_block,
  input  logic          bus_wait,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_en
);
  phase_e        phase;
  logic [AW-1:0] addr_q;
  logic          write_q;
  logic          block_q;
  logic [CW-1:0] count_q;
  logic [DW-1:0] wdata_q;
  logic [CW-1:0] idx_q;
  logic          accept;
  logic          capture_now;
  logic          wait_phase;

  assign busy        = (phase != PH_IDLE);
  assign capture_now = ph_data(phase) && !write_q;
  assign wait_phase  = ph_wait_sample(phase);

  sbm_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_block (req_block),
    .req_addr  (req_addr),
    .req_count (req_count),
    .req_wdata (req_wdata),
    .bus_wait  (bus_wait),
    .phase     (phase),
    .addr_q    (addr_q),
    .write_q   (write_q),
    .block_q   (block_q),
    .count_q   (count_q),
    .wdata_q   (wdata_q),
    .idx_q     (idx_q),
    .accept    (accept),
    .done      (done)
  );

  sbm_drive #(.AW(AW), .DW(DW), .CW(CW)) u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .addr_q      (addr_q),
    .write_q     (write_q),
    .block_q     (block_q),
    .count_q     (count_q),
    .wdata_q     (wdata_q),
    .bus_addr    (bus_addr),
    .bus_mreq    (bus_mreq),
    .bus_rd      (bus_rd),
    .bus_block   (bus_block),
    .bus_dout    (bus_dout),
    .bus_dout_en (bus_dout_en)
  );

  sbm_capture #(.DW(DW), .CW(CW)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture_now),
    .bus_din    (bus_din),
    .idx_in     (idx_q),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_idx   (word_idx)
  );

endmodule

// File: rtl/sync_bus_master_chk.sv
`timescale 1ns/1ps
module sync_bus_master_chk
  import sbm_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input phase_e        phase,
  input logic          bus_wait,
  input logic          bus_mreq,
  input logic          bus_rd,
  input logic          bus_block,
  input logic          bus_dout_en,
  input logic [AW-1:0] bus_addr,
  input logic          write_q,
  input logic          word_valid,
  input logic          capture_now,
  input logic          wait_phase,
  input logic          accept
);

  p_rd_needs_mreq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> bus_mreq);

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != PH_T1) |-> $stable(bus_addr));

  p_accept_to_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (phase == PH_T1));

  p_wait_extends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_phase && bus_wait) |=> (phase == PH_TW));

  p_wait_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_phase && !bus_wait) |=> (phase == PH_T3));

  p_word_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_now |=> word_valid);

  p_block_in_t1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_block |-> (phase == PH_T1 && bus_dout_en));

  p_write_no_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && write_q) |-> (!bus_rd && !bus_block));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_mreq && !bus_rd && !bus_dout_en));

endmodule

bind sync_bus_master sync_bus_master_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .phase       (phase),
  .bus_wait    (bus_wait),
  .bus_mreq    (bus_mreq),
  .bus_rd      (bus_rd),
  .bus_block   (bus_block),
  .bus_dout_en (bus_dout_en),
  .bus_addr    (bus_addr),
  .write_q     (write_q),
  .word_valid  (word_valid),
  .capture_now (capture_now),
  .wait_phase  (wait_phase),
  .accept      (accept)
);

// File: tb/sync_bus_master_tb.sv
`timescale 1ns/1ps
module sync_bus_master_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int NV = 10;

  // {write, block, addr[8], count[4], waits[3], wdata[16]}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h10, 4'd0,  3'd0, 16'h0000},
    {1'b0, 1'b0, 8'h11, 4'd0,  3'd2, 16'h0000},
    {1'b0, 1'b1, 8'h20, 4'd4,  3'd0, 16'h0000},
    {1'b0, 1'b1, 8'hFE, 4'd3,  3'd1, 16'h0000},
    {1'b0, 1'b1, 8'h30, 4'd0,  3'd0, 16'h0000},
    {1'b1, 1'b0, 8'h40, 4'd0,  3'd0, 16'hBEEF},
    {1'b0, 1'b0, 8'h40, 4'd0,  3'd1, 16'h0000},
    {1'b1, 1'b1, 8'h41, 4'd5,  3'd2, 16'h1234},
    {1'b0, 1'b1, 8'h40, 4'd2,  3'd3, 16'h0000},
    {1'b0, 1'b1, 8'h80, 4'd15, 3'd0, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_block = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, done, word_valid;
  logic [DW-1:0] word_data;
  logic [CW-1:0] word_idx;
  logic [AW-1:0] bus_addr;
  logic          bus_mreq, bus_rd, bus_block, bus_dout_en;
  logic          bus_wait;
  logic [DW-1:0] bus_din;
  logic [DW-1:0] bus_dout;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [2:0] wait_cfg = 3'd0;
  logic [DW-1:0] exp_mem [256];
  logic [DW-1:0] smem [256];

  always #2.5 clk = ~clk;

  sync_bus_master #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_block(req_block), .req_addr(req_addr), .req_count(req_count),
    .req_wdata(req_wdata), .busy(busy), .done(done), .word_valid(word_valid),
    .word_data(word_data), .word_idx(word_idx), .bus_addr(bus_addr),
    .bus_mreq(bus_mreq), .bus_rd(bus_rd), .bus_block(bus_block),
    .bus_wait(bus_wait), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en)
  );

  function automatic logic [DW-1:0] seed_word(input int i);
    return {8'(i), ~8'(i)} ^ 16'h3C5A;
  endfunction

  // Behavioural slave: wait states from wait_cfg, then one word per cycle.
  logic       s_act, s_data, s_wr;
  logic [7:0] s_addr;
  logic [4:0] s_n, s_idx;
  logic [2:0] s_wl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_act <= 1'b0; s_data <= 1'b0; s_wr <= 1'b0; s_addr <= '0;
      s_n <= '0; s_idx <= '0; s_wl <= '0; bus_wait <= 1'b0; bus_din <= '0;
    end else if (!s_act) begin
      if (bus_mreq) begin
        s_act    <= 1'b1;
        s_data   <= 1'b0;
        s_addr   <= bus_addr;
        s_wr     <= !bus_rd;
        s_n      <= bus_block ? ((bus_dout[CW-1:0] == '0) ? 5'd1 : 5'(bus_dout[CW-1:0])) : 5'd1;
        s_idx    <= '0;
        s_wl     <= wait_cfg;
        bus_wait <= (wait_cfg != 3'd0);
      end
    end else if (!s_data) begin
      if (bus_wait) begin
        s_wl     <= s_wl - 3'd1;
        bus_wait <= (s_wl > 3'd1);
      end else begin
        s_data  <= 1'b1;
        bus_din <= s_wr ? '0 : smem[s_addr];
      end
    end else begin
      if (s_wr) smem[s_addr] <= bus_dout;
      if (s_idx + 5'd1 >= s_n) begin
        s_act   <= 1'b0;
        bus_din <= '0;
      end else begin
        s_idx   <= s_idx + 5'd1;
        bus_din <= smem[8'(s_addr + 8'(s_idx) + 8'd1)];
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog all-R actual=%0d expected<50000", cyc);
      summary();
    end
  end

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 300) begin step(); g++; end
  endtask

  // Runs one transaction with its own collection loop and checks.
  task automatic run_txn(input logic w, input logic b, input logic [7:0] a,
                         input logic [3:0] c, input logic [2:0] wt, input logic [15:0] wd);
    int n, exp_busy, busy_cnt, words, guard;
    logic addr_ok, rd_seen, wd_ok;
    n        = (b && !w) ? ((c == 4'd0) ? 1 : int'(c)) : 1;
    exp_busy = w ? 3 + int'(wt) : 2 + int'(wt) + n;
    wait_cfg = wt;
    wait_idle();
    req_write = w; req_block = b; req_addr = a; req_count = c; req_wdata = wd;
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    // T1 sample
    chk(busy && bus_addr == a, "R2 T1 address", int'(bus_addr), int'(a));
    chk(bus_mreq && (bus_rd == !w), "R3 strobes in T1", int'({bus_mreq, bus_rd}), int'({1'b1, !w}));
    chk(bus_block == (b && !w), "R6/R7 block flag in T1", int'(bus_block), int'(b && !w));
    if (b && !w)
      chk(bus_dout_en && bus_dout == 16'(c), "R6 count on data lines", int'(bus_dout), int'(c));
    busy_cnt = 0; words = 0; guard = 0;
    addr_ok = 1'b1; rd_seen = 1'b0; wd_ok = !w;
    forever begin
      if (busy) begin
        busy_cnt++;
        if (bus_addr != a) addr_ok = 1'b0;
        if (bus_rd) rd_seen = 1'b1;
        if (w && bus_dout_en && bus_dout == wd) wd_ok = 1'b1;
      end
      if (word_valid) begin
        chk(int'(word_idx) == words, "R5 word index", int'(word_idx), words);
        chk(word_data == exp_mem[8'(a + 8'(words))], "R5/R6 word data",
            int'(word_data), int'(exp_mem[8'(a + 8'(words))]));
        words++;
      end
      if (done) break;
      if (guard > 200) break;
      guard++;
      step();
    end
    chk(done, "R8 done seen", int'(done), 1);
    chk(!bus_mreq && !bus_rd && !bus_dout_en, "R8 strobes low at done",
        int'({bus_mreq, bus_rd, bus_dout_en}), 0);
    chk(busy_cnt == exp_busy, "R4/R6/R7 busy cycles", busy_cnt, exp_busy);
    chk(words == (w ? 0 : n), "R5/R6 word count", words, w ? 0 : n);
    chk(addr_ok, "R2 address held", int'(addr_ok), 1);
    if (w) begin
      chk(!rd_seen && wd_ok, "R7 write strobes and data", int'({rd_seen, wd_ok}), 1);
      exp_mem[a] = wd;
    end
    step();
    chk(!done, "R8 done single pulse", int'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      exp_mem[i] = seed_word(i);
      smem[i]    = seed_word(i);
    end
    rst_n = 1'b0;
    repeat (3) step();
    chk(!busy && !done && !word_valid, "R1 outputs in reset", int'({busy, done, word_valid}), 0);
    rst_n = 1'b1;
    step();
    chk(!busy && !done && !word_valid, "R1 client outputs after reset", int'({busy, done, word_valid}), 0);
    chk(!bus_mreq && !bus_rd && !bus_block && !bus_dout_en, "R1 bus strobes after reset",
        int'({bus_mreq, bus_rd, bus_block, bus_dout_en}), 0);

    for (int v = 0; v < NV; v++) begin
      run_txn(VEC[v][32], VEC[v][31], VEC[v][30:23], VEC[v][22:19], VEC[v][18:16], VEC[v][15:0]);
    end

    // R9: request raised while busy is held and starts right after done
    begin
      int g, aw, bw;
      wait_cfg = 3'd3;
      wait_idle();
      req_write = 1'b0; req_block = 1'b1; req_addr = 8'h50; req_count = 4'd2;
      req_valid = 1'b1;
      step();
      req_block = 1'b0; req_addr = 8'h60; req_count = 4'd0;
      req_valid = 1'b1;
      chk(busy && bus_addr == 8'h50, "R9 first transaction owns bus", int'(bus_addr), 8'h50);
      g = 0; aw = 0;
      while (!done && g < 100) begin
        step(); g++;
        if (word_valid) begin
          chk(word_data == exp_mem[8'(8'h50 + 8'(aw))], "R9 first transaction data",
              int'(word_data), int'(exp_mem[8'(8'h50 + 8'(aw))]));
          aw++;
        end
      end
      chk(aw == 2, "R9 first transaction words", aw, 2);
      step();
      req_valid = 1'b0;
      chk(busy && bus_addr == 8'h60, "R9 held request in T1 after done", int'(bus_addr), 8'h60);
      g = 0; bw = 0;
      while (!done && g < 100) begin
        step(); g++;
        if (word_valid) begin
          chk(word_data == exp_mem[8'h60], "R9 held request data", int'(word_data), int'(exp_mem[8'h60]));
          bw++;
        end
      end
      chk(bw == 1, "R9 held request words", bw, 1);
    end

    step();
    summary();
  end

endmodule